// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 32 interrupt sources in front of a processor core. Each source is the OR of a hardware request line and a bit that software can set. An enable mask and a class mask sort every active source into one of two classes. The fast class drives a single fast-interrupt output. The normal class goes through per-source priority levels and a software mask of whole levels. A one-hot-free arbiter then picks a winner and presents that winner's vector address to the core.

Software reaches the block through a single-cycle register port. The address input carries the byte offset divided by four. Reads return data combinationally in the same cycle. Writes take effect at the next rising clock edge. Every access carries a privilege flag, and a protection bit can lock out accesses made without it.

A two-state service machine keeps a claimed interrupt from being displaced by sources of equal or lower urgency. State SVC_IDLE moves to SVC_BUSY on the transition "claim": a permitted read of the current-vector register while a normal-class source is eligible. That transition captures the winner's priority level. State SVC_BUSY moves back to SVC_IDLE on the transition "acknowledge": any permitted write to the current-vector register. Every other access leaves the state where it is.

Top module: `vic_ctrl`

## Requirements
- R1: The raw register (byte offset 0x008) reads `src_req | soft`, whatever the enable and class settings are.
- R2: The normal status (0x000) reads raw & enable & ~class. The fast status (0x004) reads raw & enable & class. The class register sits at 0x00C, with 1 meaning fast. The enable register sits at 0x010.
- R3: The enable register is read/write. Writing to 0x014 clears each enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: The soft register (0x018) is read/write. Writing to 0x01C clears each soft bit whose data bit is 1.
- R5: While the protection bit (0x020, bit 0) is 1, an access with `bus_priv` low is blocked: a write changes nothing and a read returns 0. Privileged accesses are never blocked.
- R6: The level mask (0x024, 16 bits) resets to 0xFFFF. While bit L is 0, every normal-class source at priority level L is removed from arbitration.
- R7: There are 32 read/write vector registers at 0x100 + 4*n, each resetting to 0.
- R8: Each source has a 4-bit priority register at 0x200 + 4*n, resetting to 0xF. The current-vector register (0xF00) returns the vector of the eligible source with the lowest priority value. A tie goes to the lower source number. The register returns 0 when no source is eligible.
- R9: Claim and acknowledge move the machine between SVC_IDLE and SVC_BUSY as described above. In SVC_BUSY, only sources whose priority value is strictly below the captured level are eligible.
- R10: `fiq_o` is high exactly when the fast status is nonzero. `irq_o` is high exactly when some normal-class source is eligible.
- R11: Reads of unused offsets return 0. Writes to unused offsets and to the read-only status registers change nothing.
- R12: After reset, the class, enable, soft and protection registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 32 | Level-sensitive hardware request lines |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is made in privileged mode |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access, 0 when no permitted read is made |
| fiq_o | output | 1 | Fast interrupt request to the core |
| irq_o | output | 1 | Normal interrupt request to the core |

## Verification
The properties assume that the request lines and the bus inputs are stable around each rising edge. They also assume that a read is seen once per access, because a read of the current-vector register has a side effect at the edge that ends it. The bench changes every input at a falling edge. It keeps `bus_sel` high for exactly one rising edge per access and samples read data shortly after driving it. This means each claim or acknowledge happens exactly once, and the expected service state is always known.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_BUSY = 1'b1
    } svc_state_e;

    // word addresses (byte offset / 4)
    localparam int unsigned WA_NORM_STAT = 0;
    localparam int unsigned WA_FAST_STAT = 1;
    localparam int unsigned WA_RAW       = 2;
    localparam int unsigned WA_CLASS     = 3;
    localparam int unsigned WA_ENABLE    = 4;
    localparam int unsigned WA_EN_CLR    = 5;
    localparam int unsigned WA_SOFT      = 6;
    localparam int unsigned WA_SOFT_CLR  = 7;
    localparam int unsigned WA_PROT      = 8;
    localparam int unsigned WA_LVL_MASK  = 9;
    localparam int unsigned WA_VEC_BASE  = 64;
    localparam int unsigned WA_PRI_BASE  = 128;
    localparam int unsigned WA_CUR_VEC   = 960;

endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NSRC = 32,
    parameter int PW   = 4,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] cand,
    input  logic [PW-1:0]   prio [NSRC],
    output logic            any,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);

    // scanning downward with <= lets the lower index win ties
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i] && (prio[i] <= win_prio)) begin
                any      = 1'b1;
                win_prio = prio[i];
                win_idx  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vic_vector_bank.sv
module vic_vector_bank #(
    parameter int NSRC = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] bus_idx,
    output logic [DW-1:0] bus_val,
    input  logic [IW-1:0] win_idx,
    output logic [DW-1:0] win_val
);

    logic [DW-1:0] vec_q [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           vec_q[g] <= '0;
            else if (we && (widx == IW'(g)))      vec_q[g] <= wdata;
        end
    end

    assign bus_val = vec_q[bus_idx];
    assign win_val = vec_q[win_idx];

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int DW   = 32,
    parameter int AW   = 10,
    parameter int PW   = 4,
    localparam int IW  = $clog2(NSRC),
    localparam int NLV = 1 << PW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic            bus_priv,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            fiq_o,
    output logic            irq_o
);

    svc_state_e      state_q, state_d;
    logic [PW-1:0]   held_q;
    logic [NSRC-1:0] class_q, en_q, soft_q;
    logic            prot_q;
    logic [NLV-1:0]  lvl_mask_q;
    logic [PW-1:0]   prio_q [NSRC];

    logic            acc_ok, wr_ok, rd_ok;
    logic [31:0]     a32;
    logic            hit_vec, hit_pri, hit_cur;
    logic [IW-1:0]   slot;
    logic [NSRC-1:0] raw, norm_stat, fast_stat, elig;
    logic            win_any;
    logic [IW-1:0]   win_idx;
    logic [PW-1:0]   win_prio;
    logic [DW-1:0]   vec_bus, vec_win;
    logic            claim, ack;

    assign acc_ok = bus_sel && (bus_priv || !prot_q);
    assign wr_ok  = acc_ok && bus_wr;
    assign rd_ok  = acc_ok && !bus_wr;
    assign a32    = 32'(bus_addr);
    assign hit_vec = (a32 >= WA_VEC_BASE) && (a32 < WA_VEC_BASE + NSRC);
    assign hit_pri = (a32 >= WA_PRI_BASE) && (a32 < WA_PRI_BASE + NSRC);
    assign hit_cur = (a32 == WA_CUR_VEC);
    assign slot    = IW'(a32);   // both slot ranges are NSRC-aligned

    assign raw       = src_req | soft_q;
    assign norm_stat = raw & en_q & ~class_q;
    assign fast_stat = raw & en_q & class_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        assign elig[g] = norm_stat[g] && lvl_mask_q[prio_q[g]] &&
                         ((state_q == SVC_IDLE) || (prio_q[g] < held_q));
    end

    vic_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
        .cand(elig), .prio(prio_q), .any(win_any),
        .win_idx(win_idx), .win_prio(win_prio)
    );

    vic_vector_bank #(.NSRC(NSRC), .DW(DW)) u_vec (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && hit_vec), .widx(slot),
        .wdata(bus_wdata), .bus_idx(slot), .bus_val(vec_bus),
        .win_idx(win_idx), .win_val(vec_win)
    );

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            class_q    <= '0;
            en_q       <= '0;
            soft_q     <= '0;
            prot_q     <= 1'b0;
            lvl_mask_q <= '1;
        end else if (wr_ok) begin
            unique case (a32)
                WA_CLASS:    class_q    <= NSRC'(bus_wdata);
                WA_ENABLE:   en_q       <= NSRC'(bus_wdata);
                WA_EN_CLR:   en_q       <= en_q & ~NSRC'(bus_wdata);
                WA_SOFT:     soft_q     <= NSRC'(bus_wdata);
                WA_SOFT_CLR: soft_q     <= soft_q & ~NSRC'(bus_wdata);
                WA_PROT:     prot_q     <= bus_wdata[0];
                WA_LVL_MASK: lvl_mask_q <= NLV'(bus_wdata);
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_prio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  prio_q[g] <= '1;
            else if (wr_ok && hit_pri && slot == IW'(g)) prio_q[g] <= PW'(bus_wdata);
        end
    end

    // service state machine
    assign claim = rd_ok && hit_cur && win_any;
    assign ack   = wr_ok && hit_cur;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: if (claim) state_d = SVC_BUSY;
            SVC_BUSY: if (ack)   state_d = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
            held_q  <= '1;
        end else begin
            state_q <= state_d;
            if (state_q == SVC_IDLE && claim) held_q <= win_prio;
        end
    end

    // outputs
    always_comb begin
        irq_o     = win_any;
        fiq_o     = |fast_stat;
        bus_rdata = '0;
        if (rd_ok) begin
            if (hit_vec)      bus_rdata = vec_bus;
            else if (hit_pri) bus_rdata = DW'(prio_q[slot]);
            else if (hit_cur) bus_rdata = win_any ? vec_win : '0;
            else begin
                unique case (a32)
                    WA_NORM_STAT: bus_rdata = DW'(norm_stat);
                    WA_FAST_STAT: bus_rdata = DW'(fast_stat);
                    WA_RAW:       bus_rdata = DW'(raw);
                    WA_CLASS:     bus_rdata = DW'(class_q);
                    WA_ENABLE:    bus_rdata = DW'(en_q);
                    WA_SOFT:      bus_rdata = DW'(soft_q);
                    WA_PROT:      bus_rdata = DW'(prot_q);
                    WA_LVL_MASK:  bus_rdata = DW'(lvl_mask_q);
                    default:      bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int DW   = 32,
    parameter int AW   = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_req,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic            bus_priv,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic            irq_o,
    input logic            fiq_o,
    input svc_state_e      state_q,
    input logic            prot_q,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] class_q,
    input logic [NSRC-1:0] soft_q
);

    logic [31:0] a;
    logic        ok, known;
    assign a     = 32'(bus_addr);
    assign ok    = bus_sel && (bus_priv || !prot_q);
    assign known = (a <= WA_LVL_MASK) ||
                   (a >= WA_VEC_BASE && a < WA_VEC_BASE + NSRC) ||
                   (a >= WA_PRI_BASE && a < WA_PRI_BASE + NSRC) ||
                   (a == WA_CUR_VEC);

    p_blocked_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && prot_q && !bus_priv) |-> (bus_rdata == '0));

    p_unused_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !known) |-> (bus_rdata == '0));

    p_en_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && bus_wr && a == WA_EN_CLR) |=> ((en_q & $past(NSRC'(bus_wdata))) == '0));

    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && bus_wr && a == WA_CUR_VEC) |=> (state_q == SVC_IDLE));

    p_claim_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_IDLE && ok && !bus_wr && a == WA_CUR_VEC && irq_o) |=> (state_q == SVC_BUSY));

    p_irq_needs_norm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|((src_req | soft_q) & en_q & ~class_q)));

    p_fiq_needs_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (|(en_q & class_q)));

endmodule

bind vic_ctrl vic_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_priv(bus_priv), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .fiq_o(fiq_o), .state_q(state_q), .prot_q(prot_q), .en_q(en_q),
    .class_q(class_q), .soft_q(soft_q)
);

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_o, irq_o;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    vic_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_priv(bus_priv), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
    );

    // byte offsets
    localparam logic [11:0] O_NST = 12'h000, O_FST = 12'h004, O_RAW = 12'h008,
        O_CLS = 12'h00C, O_EN = 12'h010, O_ENC = 12'h014, O_SFT = 12'h018,
        O_SFC = 12'h01C, O_PRT = 12'h020, O_LVM = 12'h024, O_VEC = 12'h100,
        O_PRI = 12'h200, O_CUR = 12'hF00;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] ofs, input logic [31:0] d, input logic priv = 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = priv;
        bus_addr = ofs[11:2]; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [11:0] ofs, output logic [31:0] d, input logic priv = 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_priv = priv; bus_addr = ofs[11:2];
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic quiet();
        @(negedge clk); src_req = '0;
        wr(O_EN, 0); wr(O_SFT, 0); wr(O_CLS, 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(O_CLS, d); check("R12 class", d, 0);
        rd(O_EN, d);  check("R12 enable", d, 0);
        rd(O_SFT, d); check("R12 soft", d, 0);
        rd(O_PRT, d); check("R12 prot", d, 0);
        rd(O_LVM, d); check("R6 level mask reset", d, 32'hFFFF);
        rd(O_VEC + 12'd20, d); check("R7 vector reset", d, 0);
        rd(O_PRI + 12'd12, d); check("R8 prio reset", d, 32'hF);
        rd(O_CUR, d); check("R8 cur idle", d, 0);
        check("R10 outputs idle", {fiq_o, irq_o}, 0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        quiet();
        @(negedge clk); src_req = 32'h00F0_0001;
        wr(O_SFT, 32'h8000_0000);
        rd(O_RAW, d); check("R1 raw", d, 32'h80F0_0001);
        rd(O_NST, d); check("R2 no enable", d, 0);
    endtask

    task automatic t_split();
        logic [31:0] d;
        quiet();
        wr(O_EN, 32'h0000_00FF); wr(O_CLS, 32'h0000_000F);
        @(negedge clk); src_req = 32'h0000_0033;
        rd(O_NST, d); check("R2 normal status", d, 32'h30);
        rd(O_FST, d); check("R2 fast status", d, 32'h03);
        #1 check("R10 fiq high", {31'd0, fiq_o}, 1);
        wr(O_CLS, 0);
        #1 check("R10 fiq low", {31'd0, fiq_o}, 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        quiet();
        wr(O_EN, 32'hFFFF_0000); wr(O_ENC, 32'h0F0F_0000);
        rd(O_EN, d); check("R3 enable clear", d, 32'hF0F0_0000);
        wr(O_ENC, 0);
        rd(O_EN, d); check("R3 zero clear no effect", d, 32'hF0F0_0000);
        wr(O_SFT, 32'h0000_FFFF); wr(O_SFC, 32'h0000_00F0);
        rd(O_SFT, d); check("R4 soft clear", d, 32'h0000_FF0F);
    endtask

    task automatic t_prot();
        logic [31:0] d;
        quiet();
        wr(O_EN, 32'h5); wr(O_PRT, 1);
        wr(O_EN, 32'hFFFF_FFFF, 1'b0);
        rd(O_EN, d); check("R5 blocked write", d, 32'h5);
        rd(O_EN, d, 1'b0); check("R5 blocked read", d, 0);
        wr(O_PRT, 0);
        rd(O_EN, d, 1'b0); check("R5 unlocked read", d, 32'h5);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        quiet();
        wr(O_PRI + 12'd12, 5); wr(O_PRI + 12'd28, 2); wr(O_PRI + 12'd36, 2);
        wr(O_VEC + 12'd12, 32'h333); wr(O_VEC + 12'd28, 32'h777); wr(O_VEC + 12'd36, 32'h999);
        wr(O_EN, 32'h0000_0288);
        @(negedge clk); src_req = 32'h0000_0288;
        #1 check("R10 irq high", {31'd0, irq_o}, 1);
        rd(O_CUR, d); check("R8 tie lower index", d, 32'h777);
        wr(O_CUR, 0);
        wr(O_ENC, 32'h80);
        rd(O_CUR, d); check("R8 next winner", d, 32'h999);
        wr(O_CUR, 0);
        wr(O_LVM, 32'hFFFB);
        rd(O_CUR, d); check("R6 level 2 masked", d, 32'h333);
        wr(O_CUR, 0);
        wr(O_LVM, 32'hFFDB);
        #1 check("R6 all masked irq low", {31'd0, irq_o}, 0);
        rd(O_CUR, d); check("R6 all masked cur", d, 0);
        wr(O_LVM, 32'hFFFF);
    endtask

    task automatic t_fsm();
        logic [31:0] d;
        quiet();
        wr(O_EN, 32'h8);
        @(negedge clk); src_req = 32'h88;
        rd(O_CUR, d); check("R9 claim vector", d, 32'h333);
        #1 check("R9 busy blocks same level", {31'd0, irq_o}, 0);
        wr(O_EN, 32'h88);
        #1 check("R9 more urgent passes", {31'd0, irq_o}, 1);
        rd(O_CUR, d); check("R9 urgent vector", d, 32'h777);
        wr(O_CUR, 0);
        wr(O_ENC, 32'h80);
        rd(O_CUR, d); check("R9 idle after ack", d, 32'h333);
        wr(O_CUR, 0);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        quiet();
        wr(O_VEC + 12'd124, 32'hDEAD_BEEF);
        rd(O_VEC + 12'd124, d); check("R7 vector rw", d, 32'hDEAD_BEEF);
        wr(12'h028, 32'hFFFF_FFFF);
        rd(12'h028, d); check("R11 unused read", d, 0);
        rd(12'h300, d); check("R11 unused high read", d, 0);
        wr(O_EN, 32'h10); wr(O_NST, 32'hFFFF_FFFF);
        rd(O_EN, d); check("R11 status write ignored", d, 32'h10);
        rd(O_NST, d); check("R11 status unchanged", d, 0);
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_raw(); t_split(); t_clear(); t_prot();
        t_arb(); t_fsm(); t_misc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule